// File: doc/BRIEF.md
# Register-Mapped SPI Master with Stalling Status Reads

This block is a serial peripheral interface master driven through a small word-addressed register port. Software sets a clock divider and a clock mode, then writes one of two transmit registers to shift 8 or 16 bits out on MOSI, most significant bit first, while the same number of bits is shifted in from MISO. The serial clock is produced from the block clock. The two idle levels and the two sampling phases give the four standard SPI modes.

There is no busy flag to poll. A controller reads one of two wait registers, and the register port holds that read with `bus_wait` until the serial clock has stopped or until the bit period of the last data bit has ended. The release of the read marks the point where chip select may be dropped. After a transfer, MOSI keeps driving the last bit sent. Software can also set the MOSI level directly. Any write that arrives while a transfer is still in flight is held until that transfer ends, and then takes effect.

An access completes on the first rising clock edge at which `bus_sel` is high and `bus_wait` is low. Read data is valid during that cycle.

Top module: `spim_master`

## Requirements
- R1: The configuration register (word 0) holds the divider DIV in bits [5:0]. Each SCLK half period lasts DIV+1 clock cycles, and an N-bit transfer produces exactly 2N SCLK edges.
- R2: The polarity bit (word 0, bit 7) sets the idle level of SCLK. With 0, SCLK rests low and the first edge rises. With 1, SCLK rests high and the first edge falls.
- R3: With the phase bit (word 0, bit 6) at 0, MISO is sampled on the odd (leading) edges and MOSI changes on the even (trailing) edges. With 1, MOSI changes on the leading edges and MISO is sampled on the trailing edges.
- R4: A write to word 2 starts a transfer of wdata[7:0]. A write to word 3 starts a transfer of wdata[15:0]. Bits are sent most significant first.
- R5: When a transfer ends, MOSI stays at the least significant bit that was sent, until the next transfer or a MOSI write.
- R6: Word 4 reads the 8 bits most recently received and word 5 reads the 16 bits most recently received, with the newest bit in bit 0, across transfer boundaries.
- R7: A read of word 6 is held from the cycle in which a transfer is accepted for 2N(DIV+1) cycles, until no SCLK edge remains, and then returns 1.
- R8: A read of word 7 is held until the last bit period is over and then returns 1. With phase 0 this is the same cycle as R7. With phase 1 it is a further DIV+1 cycles.
- R9: Writing word 1 drives MOSI to wdata[0] at once when no transfer is running. A read of word 1 returns the MOSI level.
- R10: Any write issued while a transfer is running is held until the R8 condition is met, and then takes effect. A transmit write held this way starts the next transfer.
- R11: Reset clears DIV, polarity and phase, drives MOSI and SCLK low, and clears the received bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid when the access completes |
| bus_wait | output | 1 | Holds the current access |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
A slave model is driven from SCLK itself. It sends its own pattern and records MOSI, and it runs in all four modes, at both widths, at DIV 0 and DIV 3. A wrong phase decode would show up as shifted or mixed bits in both directions, and a wrong divider or edge count would change the number of SCLK edges. The bench counts how many cycles each wait-register read is held. A design that released the data wait together with the clock wait in phase 1, or that released either one a cycle early or late, fails at those exact counts. Back-to-back transmit writes check that a second write is held and not dropped or merged. Checks after each transfer confirm that MOSI stays on the LSB and that the receive history carries over from one transfer to the next.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int DATA_W   = 16;
    localparam int NARROW_W = 8;
    localparam int ADDR_W   = 4;
    localparam int DIV_W    = 6;
    localparam int EDGE_W   = $clog2(2 * DATA_W + 1);

    typedef enum logic [ADDR_W-1:0] {
        RA_CFG        = 4'd0,
        RA_MOSI       = 4'd1,
        RA_TX_NARROW  = 4'd2,
        RA_TX_WIDE    = 4'd3,
        RA_RX_NARROW  = 4'd4,
        RA_RX_WIDE    = 4'd5,
        RA_SCLK_WAIT  = 4'd6,
        RA_DATA_WAIT  = 4'd7
    } reg_addr_e;

    // One SCLK edge event as seen by the shifter
    typedef struct packed {
        logic ev;    // an SCLK edge happens at this clock edge
        logic lead;  // the edge is an odd (leading) edge
        logic last;  // the edge is the final edge of the transfer
    } sclk_evt_t;

    function automatic logic [EDGE_W-1:0] edges_for(input logic wide);
        return wide ? EDGE_W'(2 * DATA_W) : EDGE_W'(2 * NARROW_W);
    endfunction

    function automatic logic [DATA_W-1:0] align_tx(input logic wide,
                                                  input logic [DATA_W-1:0] d);
        return wide ? d : {d[NARROW_W-1:0], {(DATA_W - NARROW_W){1'b0}}};
    endfunction

endpackage

// File: rtl/spim_sclk_gen.sv
module spim_sclk_gen
    import spim_pkg::*;
#(
    parameter int DW = DIV_W,
    parameter int EW = EDGE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [EW-1:0] n_edges,
    input  logic [DW-1:0] div,
    input  logic          cpha,
    input  logic          cpol,
    output logic          sclk,
    output sclk_evt_t     evt,
    output logic          sclk_idle,
    output logic          data_idle
);

    logic [DW-1:0] cnt_q;
    logic [EW-1:0] left_q;
    logic          tail_q;
    logic          phase_q;
    logic          running;

    assign running = (left_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            left_q  <= '0;
            tail_q  <= 1'b0;
            phase_q <= 1'b0;
        end else if (start) begin
            cnt_q   <= div;
            left_q  <= n_edges;
            tail_q  <= 1'b0;
        end else if (running) begin
            if (cnt_q == '0) begin
                phase_q <= ~phase_q;
                left_q  <= left_q - EW'(1);
                cnt_q   <= div;
                if (left_q == EW'(1) && cpha) begin
                    tail_q <= 1'b1;
                end
            end else begin
                cnt_q <= cnt_q - DW'(1);
            end
        end else if (tail_q) begin
            if (cnt_q == '0) begin
                tail_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - DW'(1);
            end
        end
    end

    always_comb begin
        evt.ev   = running && (cnt_q == '0);
        evt.lead = ~left_q[0];
        evt.last = (left_q == EW'(1));
    end

    assign sclk      = phase_q ^ cpol;
    assign sclk_idle = ~running;
    assign data_idle = ~running & ~tail_q;

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
    import spim_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [W-1:0]  load,
    input  logic          cpha,
    input  sclk_evt_t     evt,
    input  logic          miso,
    input  logic          force_we,
    input  logic          force_val,
    output logic          mosi,
    output logic [W-1:0]  rx
);

    logic [W-1:0] tx_q;
    logic         sample_now;
    logic         shift_now;

    // Phase 0 samples on leading edges, phase 1 on trailing edges
    assign sample_now = evt.ev && (evt.lead != cpha);
    assign shift_now  = evt.ev && (evt.lead == cpha) && !evt.last;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
            mosi <= 1'b0;
        end else if (force_we) begin
            mosi <= force_val;
        end else if (start) begin
            if (!cpha) begin
                mosi <= load[W-1];
                tx_q <= {load[W-2:0], 1'b0};
            end else begin
                tx_q <= load;
            end
        end else if (shift_now) begin
            mosi <= tx_q[W-1];
            tx_q <= {tx_q[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx <= '0;
        end else if (sample_now) begin
            rx <= {rx[W-2:0], miso};
        end
    end

endmodule

// File: rtl/spim_regif.sv
module spim_regif
    import spim_pkg::*;
#(
    parameter int DW = DIV_W,
    parameter int W  = DATA_W,
    parameter int AW = ADDR_W,
    parameter int EW = EDGE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_sel,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    output logic          bus_wait,
    input  logic          sclk_idle,
    input  logic          data_idle,
    input  logic          mosi,
    input  logic [W-1:0]  rx,
    output logic [DW-1:0] div,
    output logic          cpha,
    output logic          cpol,
    output logic          start,
    output logic [W-1:0]  load,
    output logic [EW-1:0] n_edges,
    output logic          force_we,
    output logic          force_val
);

    reg_addr_e addr_e;
    logic      wr_hold;
    logic      rd_hold;
    logic      wr_acc;
    logic      wide;

    assign addr_e  = reg_addr_e'(bus_addr);
    assign wr_hold = bus_we && !data_idle;
    assign rd_hold = !bus_we &&
                     (((addr_e == RA_SCLK_WAIT) && !sclk_idle) ||
                      ((addr_e == RA_DATA_WAIT) && !data_idle));
    assign bus_wait = bus_sel && (wr_hold || rd_hold);
    assign wr_acc   = bus_sel && bus_we && !bus_wait;

    assign wide      = (addr_e == RA_TX_WIDE);
    assign start     = wr_acc && ((addr_e == RA_TX_NARROW) || wide);
    assign load      = align_tx(wide, bus_wdata);
    assign n_edges   = edges_for(wide);
    assign force_we  = wr_acc && (addr_e == RA_MOSI);
    assign force_val = bus_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            div  <= '0;
            cpha <= 1'b0;
            cpol <= 1'b0;
        end else if (wr_acc && addr_e == RA_CFG) begin
            div  <= bus_wdata[DW-1:0];
            cpha <= bus_wdata[DW];
            cpol <= bus_wdata[DW+1];
        end
    end

    always_comb begin
        case (addr_e)
            RA_CFG:       bus_rdata = W'({cpol, cpha, div});
            RA_MOSI:      bus_rdata = W'(mosi);
            RA_RX_NARROW: bus_rdata = W'(rx[NARROW_W-1:0]);
            RA_RX_WIDE:   bus_rdata = rx;
            RA_SCLK_WAIT: bus_rdata = W'(1);
            RA_DATA_WAIT: bus_rdata = W'(1);
            default:      bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/spim_master.sv
module spim_master
    import spim_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_wait,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    logic [DW-1:0]     div_w;
    logic              cpha_w;
    logic              cpol_w;
    logic              start_w;
    logic [DATA_W-1:0] load_w;
    logic [EDGE_W-1:0] n_edges_w;
    logic              force_we_w;
    logic              force_val_w;
    logic              sclk_idle_w;
    logic              data_idle_w;
    logic [DATA_W-1:0] rx_w;
    sclk_evt_t         evt_w;

    spim_regif #(.DW(DW), .W(DATA_W), .AW(ADDR_W), .EW(EDGE_W)) u_regif (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_wait  (bus_wait),
        .sclk_idle (sclk_idle_w),
        .data_idle (data_idle_w),
        .mosi      (spi_mosi),
        .rx        (rx_w),
        .div       (div_w),
        .cpha      (cpha_w),
        .cpol      (cpol_w),
        .start     (start_w),
        .load      (load_w),
        .n_edges   (n_edges_w),
        .force_we  (force_we_w),
        .force_val (force_val_w)
    );

    spim_sclk_gen #(.DW(DW), .EW(EDGE_W)) u_sclk (
        .clk       (clk),
        .rst       (rst),
        .start     (start_w),
        .n_edges   (n_edges_w),
        .div       (div_w),
        .cpha      (cpha_w),
        .cpol      (cpol_w),
        .sclk      (spi_sclk),
        .evt       (evt_w),
        .sclk_idle (sclk_idle_w),
        .data_idle (data_idle_w)
    );

    spim_shifter #(.W(DATA_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .start     (start_w),
        .load      (load_w),
        .cpha      (cpha_w),
        .evt       (evt_w),
        .miso      (spi_miso),
        .force_we  (force_we_w),
        .force_val (force_val_w),
        .mosi      (spi_mosi),
        .rx        (rx_w)
    );

endmodule

// File: rtl/spim_master_chk.sv
module spim_master_chk
    import spim_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_wait,
    input logic              spi_sclk,
    input logic              spi_mosi,
    input logic              sclk_idle,
    input logic              data_idle,
    input logic              cpol
);

    AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (rst)
        sclk_idle |-> (spi_sclk == cpol)); // R2

    AST_MOSI_PARKED: assert property (@(posedge clk) disable iff (rst)
        (sclk_idle && $past(sclk_idle) && !$past(bus_sel && bus_we && !bus_wait))
        |-> $stable(spi_mosi)); // R5

    AST_SCLK_READ_HELD: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we && bus_addr == RA_SCLK_WAIT && !sclk_idle)
        |-> bus_wait); // R7

    AST_SCLK_READ_ONE: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we && bus_addr == RA_SCLK_WAIT && !bus_wait)
        |-> (bus_rdata == DATA_W'(1))); // R7

    AST_DATA_AFTER_SCLK: assert property (@(posedge clk) disable iff (rst)
        data_idle |-> sclk_idle); // R8

    AST_DATA_READ_ONE: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we && bus_addr == RA_DATA_WAIT && !bus_wait)
        |-> (bus_rdata == DATA_W'(1))); // R8

    AST_WRITE_HELD: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_we && !data_idle) |-> bus_wait); // R10

endmodule

bind spim_master spim_master_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .bus_wait  (bus_wait),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi),
    .sclk_idle (sclk_idle_w),
    .data_idle (data_idle_w),
    .cpol      (cpol_w)
);

// File: tb/spim_master_tb.sv
module spim_master_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_sel;
    logic        bus_we;
    logic [3:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        bus_wait;
    logic        spi_sclk;
    logic        spi_mosi;
    logic        spi_miso;

    int checks = 0;
    int errors = 0;

    // slave model state
    logic        s_act = 1'b0;
    logic        s_pha = 1'b0;
    logic [15:0] s_tx  = '0;
    logic [31:0] s_rx  = '0;
    int          s_cnt = 0;
    int          s_ptr = -1;
    logic [31:0] hist  = '0;

    always #2 clk = ~clk;  // 250 MHz

    spim_master u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_wait  (bus_wait),
        .spi_sclk  (spi_sclk),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso)
    );

    always @(spi_sclk) begin
        if (s_act) begin
            s_cnt = s_cnt + 1;
            if (((s_cnt % 2) == 1) == (s_pha == 1'b0)) begin
                s_rx = {s_rx[30:0], spi_mosi};
            end else if (s_ptr >= 0) begin
                spi_miso = s_tx[s_ptr];
                s_ptr = s_ptr - 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [15:0] d, output int w);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        #1;
        w = 0;
        while (bus_wait) begin
            w++;
            @(negedge clk); #1;
        end
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [15:0] d, output int w);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        w = 0;
        while (bus_wait) begin
            w++;
            @(negedge clk); #1;
        end
        d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic test_reset();
        logic [15:0] d;
        int w;
        @(negedge clk);
        chk(spi_sclk == 1'b0, "R11 sclk", spi_sclk, 0);
        chk(spi_mosi == 1'b0, "R11 mosi", spi_mosi, 0);
        bus_read(4'd5, d, w);
        chk(d == 16'h0, "R11 rx", d, 0);
        bus_read(4'd0, d, w);
        chk(d == 16'h0, "R11 cfg", d, 0);
        bus_read(4'd6, d, w);
        chk(w == 0 && d == 16'd1, "R7 idle read", w, 0);
    endtask

    task automatic test_force();
        logic [15:0] d;
        int w;
        bus_write(4'd1, 16'h0001, w);
        @(negedge clk);
        chk(spi_mosi == 1'b1, "R9 force high", spi_mosi, 1);
        bus_read(4'd1, d, w);
        chk(d == 16'd1, "R9 readback", d, 1);
        bus_write(4'd1, 16'h0000, w);
        @(negedge clk);
        chk(spi_mosi == 1'b0, "R9 force low", spi_mosi, 0);
    endtask

    task automatic run_xfer(input int div, input int mode, input bit wide,
                            input logic [15:0] txd, input logic [15:0] sd,
                            input bit meas_data);
        logic [15:0] d;
        int w;
        int n  = wide ? 16 : 8;
        int h  = div + 1;
        bit pol = mode[1];
        bit pha = mode[0];
        logic [15:0] txm = wide ? txd : {8'h0, txd[7:0]};
        logic [15:0] sdm = wide ? sd  : {8'h0, sd[7:0]};
        bus_write(4'd0, 16'({pol, pha, 6'(div)}), w);
        @(negedge clk);
        chk(spi_sclk == pol, "R2 idle level", spi_sclk, pol);
        s_pha = pha; s_tx = sdm; s_cnt = 0; s_rx = '0;
        if (!pha) begin
            spi_miso = sdm[n-1];
            s_ptr = n - 2;
        end else begin
            s_ptr = n - 1;
        end
        s_act = 1'b1;
        bus_write(wide ? 4'd3 : 4'd2, txd, w);
        if (!meas_data) begin
            bus_read(4'd6, d, w);
            chk(w == 2 * n * h, "R7 sclk wait", w, 2 * n * h);
            chk(d == 16'd1, "R7 value", d, 1);
            bus_read(4'd7, d, w);
            chk(w == (pha ? h - 1 : 0), "R8 data wait after sclk", w, pha ? h - 1 : 0);
        end else begin
            bus_read(4'd7, d, w);
            chk(w == 2 * n * h + (pha ? h : 0), "R8 data wait", w, 2 * n * h + (pha ? h : 0));
            chk(d == 16'd1, "R8 value", d, 1);
        end
        s_act = 1'b0;
        chk(s_cnt == 2 * n, "R1 edge count", s_cnt, 2 * n);
        chk(s_rx[15:0] == txm, "R4 R3 mosi bits", s_rx[15:0], txm);
        chk(spi_mosi == txd[0], "R5 lsb held", spi_mosi, txd[0]);
        chk(spi_sclk == pol, "R2 sclk parked", spi_sclk, pol);
        hist = (hist << n) | 32'(sdm);
        bus_read(4'd5, d, w);
        chk(d == hist[15:0], "R6 R3 rx wide", d, hist[15:0]);
        bus_read(4'd4, d, w);
        chk(d == {8'h0, hist[7:0]}, "R6 rx narrow", d, hist[7:0]);
    endtask

    task automatic test_back_to_back();
        int w;
        logic [15:0] d;
        bus_write(4'd0, 16'h0001, w);  // div 1, mode 0
        s_pha = 1'b0; s_tx = '0; s_cnt = 0; s_rx = '0; s_ptr = -1;
        spi_miso = 1'b0;
        s_act = 1'b1;
        bus_write(4'd3, 16'hA5C3, w);
        bus_write(4'd2, 16'h005A, w);
        chk(w == 64, "R10 write held", w, 64);
        bus_read(4'd7, d, w);
        s_act = 1'b0;
        chk(s_cnt == 48, "R10 edges", s_cnt, 48);
        chk(s_rx[23:0] == 24'hA5C35A, "R10 both sent", s_rx[23:0], 24'hA5C35A);
        chk(spi_mosi == 1'b0, "R5 lsb after pair", spi_mosi, 0);
        bus_read(4'd5, d, w);
        chk(d == 16'h0, "R6 rx zeros", d, 0);
        hist = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst = 1'b1; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        spi_miso = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        test_reset();
        test_force();
        for (int dv = 0; dv < 2; dv++) begin
            for (int m = 0; m < 4; m++) begin
                run_xfer(dv * 3, m, 1'b0, 16'(8'hB1 + m * 16 + dv), 16'(8'h6D ^ (m * 5)), m[0] ^ dv[0]);
                run_xfer(dv * 3, m, 1'b1, 16'hC38E ^ 16'(m * 257 + dv), 16'h9A53 ^ 16'(m * 4369), !(m[0] ^ dv[0]));
            end
        end
        test_back_to_back();
        test_force();
        summary();
    end

endmodule